// File: doc/BRIEF.md
# Bus address break comparator

This block watches every access on a 16-bit processor bus. It sets a break flag when an access matches a programmed break address. The kind of access must also match the programmed mode. When data comparison is switched on, one byte lane of the data bus must also equal the programmed break data. The lane is chosen from the access size, the parity of the address and the bus width of the region being accessed. The break flag drives a level interrupt request, gated by an enable bit.

Software programs the block through a small byte-wide register port that holds six registers. A control register selects the mode, data comparison and full or partial address comparison. A status register holds the flag, the enable bit and six reserved bits. The break address and the break data are each split into a high register and a low register. The flag clears only through a handshake: software reads it as 1, then writes 0 to it.

Top module: `bus_brk_cmp`

## Requirements
- R1: After reset, the break address registers read 0xFF (select 2, high byte) and 0xFF (select 3, low byte). The break data registers (select 4 high, select 5 low) and the control register (select 0) read 0x00. The status register (select 1) reads 0x3F, and the interrupt output is 0.
- R2: The control, break address and break data registers read back what was written. In the status register, bits 5:0 always read 1, bit 7 is the flag and bit 6 is the interrupt enable.
- R3: Control bits 1:0 = 0 select instruction-fetch mode. In this mode, a fetch whose address equals the break address sets the flag at the next clock edge. A fetch to a different address leaves the flag clear.
- R4: Control bits 1:0 = 1 match only data reads (non-fetch), = 2 only writes, and = 3 either a data read or a write. An access of any other kind leaves the flag clear.
- R5: Control bit 3 = 1 compares all 16 address bits. Control bit 3 = 0 ignores address bit 0.
- R6: With control bit 2 = 1, the data compare is added. Bus byte accesses (word = 0) always compare data bus bits 15:8 with the high break data byte, at both even and odd addresses.
- R7: Region codes are 0 ROM, 1 RAM, 2 I/O with an 8-bit bus, and 3 I/O with a 16-bit bus. A word access to an odd address in region 0, 1 or 3 compares bus bits 7:0 with the low break data byte. Word accesses to even addresses, and all word accesses to region 2, use bits 15:8 against the high byte.
- R8: Writing 0 to status bit 7 clears the flag only if the status register was read with the flag at 1 since the last status write. A write of 0 without such a read leaves the flag set. Writing 1 to bit 7 never sets it.
- R9: A clearing write in the same cycle as a new match leaves the flag set.
- R10: The interrupt output is a registered level. It equals the AND of the flag and the enable as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select (0 control, 1 status, 2/3 address high/low, 4/5 data high/low) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 16 | Access address |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_word | input | 1 | 1 word access, 0 byte access |
| bus_fetch | input | 1 | Access is an instruction fetch |
| bus_region | input | 2 | Target region code |
| bus_data | input | 16 | Data bus |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit address and data bus, a 3-bit register select and a registered interrupt. These values give the full 16-bit address compare with and without bit 0, and both byte lanes on odd and even addresses in every region code. They also give the one-cycle lag between the flag and the interrupt. The registered-interrupt setting makes the ordering within a cycle visible at the port: a match in the same cycle as a clearing write can be seen there, and so can an interrupt that drops one cycle after the flag clears.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
   typedef enum logic [1:0] {
      RGN_ROM  = 2'd0,
      RGN_RAM  = 2'd1,
      RGN_IO8  = 2'd2,
      RGN_IO16 = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      BRK_FETCH = 2'd0,
      BRK_READ  = 2'd1,
      BRK_WRITE = 2'd2,
      BRK_ANY   = 2'd3
   } brk_mode_e;

   typedef struct packed {
      logic      full_addr;
      logic      data_en;
      brk_mode_e mode;
   } ctrl_t;

   localparam int CTRL_W     = 4;
   localparam int SEL_CTRL   = 0;
   localparam int SEL_STATUS = 1;
   localparam int SEL_BAR_HI = 2;
   localparam int SEL_BAR_LO = 3;
   localparam int SEL_BDR_HI = 4;
   localparam int SEL_BDR_LO = 5;
endpackage

// File: rtl/bbc_regs.sv
module bbc_regs
   import bbc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SEL_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    reg_sel,
   input  logic                reg_wr,
   input  logic [DATA_W/2-1:0] reg_wdata,
   output ctrl_t               ctrl,
   output logic [DATA_W-1:0]   bar,
   output logic [DATA_W-1:0]   bdr
);
   localparam int LANE_W = DATA_W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         bar  <= '1;
         bdr  <= '0;
      end else if (reg_wr) begin
         if (reg_sel == SEL_W'(SEL_CTRL))   ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (reg_sel == SEL_W'(SEL_BAR_HI)) bar[DATA_W-1:LANE_W] <= reg_wdata;
         if (reg_sel == SEL_W'(SEL_BAR_LO)) bar[LANE_W-1:0]      <= reg_wdata;
         if (reg_sel == SEL_W'(SEL_BDR_HI)) bdr[DATA_W-1:LANE_W] <= reg_wdata;
         if (reg_sel == SEL_W'(SEL_BDR_LO)) bdr[LANE_W-1:0]      <= reg_wdata;
      end
   end
endmodule

// File: rtl/bbc_match.sv
module bbc_match
   import bbc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  ctrl_t             ctrl,
   input  logic [DATA_W-1:0] bar,
   input  logic [DATA_W-1:0] bdr,
   input  logic              bus_valid,
   input  logic [DATA_W-1:0] bus_addr,
   input  logic              bus_rnw,
   input  logic              bus_word,
   input  logic              bus_fetch,
   input  logic [1:0]        bus_region,
   input  logic [DATA_W-1:0] bus_data,
   output logic              hit
);
   localparam int LANE_W = DATA_W / 2;

   logic kind_ok, addr_ok, data_ok, use_hi;

   always_comb begin
      unique case (ctrl.mode)
         BRK_FETCH: kind_ok = bus_fetch;
         BRK_READ:  kind_ok = bus_rnw && !bus_fetch;
         BRK_WRITE: kind_ok = !bus_rnw && !bus_fetch;
         default:   kind_ok = !bus_fetch;
      endcase
   end

   assign addr_ok = ctrl.full_addr ? (bus_addr == bar)
                                   : (bus_addr[DATA_W-1:1] == bar[DATA_W-1:1]);

   // Upper lane unless a word access lands on an odd address of a 16-bit region
   assign use_hi = !bus_word || (region_e'(bus_region) == RGN_IO8) || !bus_addr[0];

   assign data_ok = !ctrl.data_en ||
                    (use_hi ? (bus_data[DATA_W-1:LANE_W] == bdr[DATA_W-1:LANE_W])
                            : (bus_data[LANE_W-1:0] == bdr[LANE_W-1:0]));

   assign hit = bus_valid && kind_ok && addr_ok && data_ok;
endmodule

// File: rtl/bbc_flag.sv
module bbc_flag #(
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic st_wr,
   input  logic st_rd,
   input  logic wr_flag,
   input  logic wr_ie,
   output logic flag_q,
   output logic ie_q,
   output logic armed_q,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         ie_q    <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (hit)                              flag_q <= 1'b1;
         else if (st_wr && !wr_flag && armed_q) flag_q <= 1'b0;
         if (st_wr)                            ie_q   <= wr_ie;
         if (st_wr)                            armed_q <= 1'b0;
         else if (st_rd && flag_q)             armed_q <= 1'b1;
      end
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_q && ie_q;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = flag_q && ie_q;
      end
   endgenerate
endmodule

// File: rtl/bus_brk_cmp.sv
module bus_brk_cmp
   import bbc_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int SEL_W          = 3,
   parameter bit IRQ_REGISTERED = 1'b1,
   localparam int LANE_W        = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [LANE_W-1:0] reg_wdata,
   output logic [LANE_W-1:0] reg_rdata,
   input  logic              bus_valid,
   input  logic [DATA_W-1:0] bus_addr,
   input  logic              bus_rnw,
   input  logic              bus_word,
   input  logic              bus_fetch,
   input  logic [1:0]        bus_region,
   input  logic [DATA_W-1:0] bus_data,
   output logic              irq_o
);
   generate
      if (DATA_W % 2 != 0 || LANE_W < 8) begin : g_bad_width
         $error("bus_brk_cmp: DATA_W must be even and at least 16");
      end
      if (SEL_W < 3) begin : g_bad_sel
         $error("bus_brk_cmp: SEL_W must be at least 3");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [DATA_W-1:0] bar, bdr;
   logic              hit, flag_q, ie_q, armed_q, st_wr, st_rd;

   assign st_wr = reg_wr && (reg_sel == SEL_W'(SEL_STATUS));
   assign st_rd = reg_rd && (reg_sel == SEL_W'(SEL_STATUS));

   bbc_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .ctrl(ctrl), .bar(bar), .bdr(bdr)
   );

   bbc_match #(.DATA_W(DATA_W)) u_match (
      .ctrl(ctrl), .bar(bar), .bdr(bdr), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_word(bus_word),
      .bus_fetch(bus_fetch), .bus_region(bus_region), .bus_data(bus_data),
      .hit(hit)
   );

   bbc_flag #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_flag (
      .clk(clk), .rst_n(rst_n), .hit(hit), .st_wr(st_wr), .st_rd(st_rd),
      .wr_flag(reg_wdata[LANE_W-1]), .wr_ie(reg_wdata[LANE_W-2]),
      .flag_q(flag_q), .ie_q(ie_q), .armed_q(armed_q), .irq_o(irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_W'(SEL_CTRL):   reg_rdata = LANE_W'(ctrl);
         SEL_W'(SEL_STATUS): reg_rdata = {flag_q, ie_q, {(LANE_W-2){1'b1}}};
         SEL_W'(SEL_BAR_HI): reg_rdata = bar[DATA_W-1:LANE_W];
         SEL_W'(SEL_BAR_LO): reg_rdata = bar[LANE_W-1:0];
         SEL_W'(SEL_BDR_HI): reg_rdata = bdr[DATA_W-1:LANE_W];
         SEL_W'(SEL_BDR_LO): reg_rdata = bdr[LANE_W-1:0];
         default:            reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/bbc_chk.sv
module bbc_chk #(
   parameter int LANE_W         = 8,
   parameter int SEL_W          = 3,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hit,
   input logic              flag_q,
   input logic              ie_q,
   input logic              armed_q,
   input logic              st_wr,
   input logic [LANE_W-1:0] reg_wdata,
   input logic [SEL_W-1:0]  reg_sel,
   input logic [LANE_W-1:0] reg_rdata,
   input logic              irq_o
);
   // R3 R9: a match always leaves the flag set at the next edge
   a_r9_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);

   // R3: the flag only rises because of a match
   a_r3_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(hit));

   // R8: the flag only falls after an armed write of 0
   a_r8_fall_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(st_wr && armed_q && !reg_wdata[LANE_W-1]));

   // R2: reserved status bits read as ones
   a_r2_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_W'(1)) |-> (&reg_rdata[LANE_W-3:0]));

   generate
      if (IRQ_REGISTERED) begin : g_irq_chk
         // R10: the interrupt follows flag AND enable one cycle later
         a_r10_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && ie_q) |=> irq_o);
         a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
            !(flag_q && ie_q) |=> !irq_o);
      end
   endgenerate
endmodule

bind bus_brk_cmp bbc_chk #(.LANE_W(LANE_W), .SEL_W(SEL_W), .IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .hit(hit), .flag_q(flag_q), .ie_q(ie_q),
   .armed_q(armed_q), .st_wr(st_wr), .reg_wdata(reg_wdata), .reg_sel(reg_sel),
   .reg_rdata(reg_rdata), .irq_o(irq_o)
);

// File: tb/sim_bus_brk_cmp.sv
module sim_bus_brk_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        bus_valid = 1'b0, bus_rnw = 1'b0, bus_word = 1'b0, bus_fetch = 1'b0;
   logic [15:0] bus_addr = '0, bus_data = '0;
   logic [1:0]  bus_region = '0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bus_brk_cmp u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_word(bus_word),
      .bus_fetch(bus_fetch), .bus_region(bus_region), .bus_data(bus_data),
      .irq_o(irq_o)
   );

   // behavioural reference state
   logic [7:0]  m_ctrl = 8'h00;
   logic [15:0] m_bar = 16'hFFFF, m_bdr = 16'h0000;
   bit m_flag = 0, m_ie = 0, m_armed = 0, m_irq = 0;

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] m_rd(input logic [2:0] s);
      case (s)
         3'd0: return m_ctrl;
         3'd1: return {m_flag, m_ie, 6'h3F};
         3'd2: return m_bar[15:8];
         3'd3: return m_bar[7:0];
         3'd4: return m_bdr[15:8];
         3'd5: return m_bdr[7:0];
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit m_match();
      bit kind, adr, dat;
      int mode = int'(m_ctrl[1:0]);
      if (!bus_valid) return 0;
      if (mode == 0)      kind = bus_fetch;
      else if (bus_fetch) kind = 0;
      else if (mode == 1) kind = bus_rnw;
      else if (mode == 2) kind = !bus_rnw;
      else                kind = 1;
      if (m_ctrl[3]) adr = (bus_addr == m_bar);
      else           adr = ((bus_addr | 16'h1) == (m_bar | 16'h1));
      if (!m_ctrl[2]) dat = 1;
      else if (bus_word && bus_region != 2'd2 && bus_addr[0]) dat = (bus_data[7:0] == m_bdr[7:0]);
      else dat = (bus_data[15:8] == m_bdr[15:8]);
      return kind && adr && dat;
   endfunction

   // one clock: predict, advance, commit, compare every cycle
   task automatic step();
      bit hit = m_match();
      bit swr = reg_wr && reg_sel == 3'd1;
      bit srd = reg_rd && reg_sel == 3'd1;
      bit n_flag = m_flag, n_armed = m_armed, n_ie = m_ie, n_irq;
      logic [7:0] n_ctrl = m_ctrl;
      logic [15:0] n_bar = m_bar, n_bdr = m_bdr;
      if (swr && !reg_wdata[7] && m_armed) n_flag = 0;
      if (hit) n_flag = 1;
      if (swr) begin n_armed = 0; n_ie = reg_wdata[6]; end
      else if (srd && m_flag) n_armed = 1;
      n_irq = m_flag && m_ie;
      if (reg_wr) case (reg_sel)
         3'd0: n_ctrl = {4'h0, reg_wdata[3:0]};
         3'd2: n_bar[15:8] = reg_wdata;
         3'd3: n_bar[7:0] = reg_wdata;
         3'd4: n_bdr[15:8] = reg_wdata;
         3'd5: n_bdr[7:0] = reg_wdata;
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      m_flag = n_flag; m_armed = n_armed; m_ie = n_ie; m_irq = n_irq;
      m_ctrl = n_ctrl; m_bar = n_bar; m_bdr = n_bdr;
      chk({15'd0, irq_o}, {15'd0, m_irq}, "MODEL irq");
      chk({8'd0, reg_rdata}, {8'd0, m_rd(reg_sel)}, "MODEL rdata");
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] v);
      reg_sel = s; reg_wdata = v; reg_wr = 1; step(); reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] s, input logic [7:0] exp, input string tag);
      reg_sel = s; reg_rd = 1; #1;
      chk({8'd0, reg_rdata}, {8'd0, exp}, tag);
      step(); reg_rd = 0;
   endtask

   task automatic acc(input logic [15:0] a, input bit rnw, input bit word, input bit fetch,
                      input logic [1:0] rgn, input logic [15:0] d);
      bus_addr = a; bus_rnw = rnw; bus_word = word; bus_fetch = fetch;
      bus_region = rgn; bus_data = d; bus_valid = 1;
      step();
      bus_valid = 0;
   endtask

   task automatic clear_flag(input logic [7:0] ie_bits);
      rd(3'd1, {1'b1, ie_bits[6], 6'h3F}, "R8 arm read");
      wr(3'd1, ie_bits);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      chk({15'd0, irq_o}, 16'd0, "R1 irq");
      rd(3'd2, 8'hFF, "R1 addr hi");
      rd(3'd3, 8'hFF, "R1 addr lo");
      rd(3'd4, 8'h00, "R1 data hi");
      rd(3'd5, 8'h00, "R1 data lo");
      rd(3'd0, 8'h00, "R1 ctrl");
      rd(3'd1, 8'h3F, "R1 status");

      // R2 read-back
      wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'hA5); wr(3'd5, 8'h5A);
      rd(3'd2, 8'h12, "R2 addr hi"); rd(3'd3, 8'h34, "R2 addr lo");
      rd(3'd4, 8'hA5, "R2 data hi"); rd(3'd5, 8'h5A, "R2 data lo");
      wr(3'd0, 8'h08); rd(3'd0, 8'h08, "R2 ctrl");
      wr(3'd1, 8'h01); rd(3'd1, 8'h3F, "R2 status reserved");

      // R3 fetch mode, full address
      acc(16'h1236, 1, 1, 1, 2'd0, 16'h0);
      rd(3'd1, 8'h3F, "R3 other address");
      acc(16'h1234, 1, 1, 1, 2'd0, 16'h0);
      rd(3'd1, 8'hBF, "R3 fetch hit");
      // R8 write 0 after the arming read above clears; check unarmed case next
      wr(3'd1, 8'h00);
      rd(3'd1, 8'h3F, "R8 armed clear");
      acc(16'h1234, 1, 1, 1, 2'd0, 16'h0);
      wr(3'd1, 8'h00);
      rd(3'd1, 8'hBF, "R8 unarmed write keeps flag");
      wr(3'd1, 8'h80);
      wr(3'd1, 8'h00);
      rd(3'd1, 8'hBF, "R8 write 1 disarms");
      wr(3'd1, 8'h00);
      rd(3'd1, 8'h3F, "R8 cleared");

      // R5 partial vs full address
      acc(16'h1235, 1, 1, 1, 2'd0, 16'h0);
      rd(3'd1, 8'h3F, "R5 full ignores neighbour");
      wr(3'd0, 8'h00);
      acc(16'h1235, 1, 1, 1, 2'd0, 16'h0);
      rd(3'd1, 8'hBF, "R5 partial matches neighbour");
      wr(3'd1, 8'h00);
      rd(3'd1, 8'h3F, "R5 cleared");

      // R4 read mode
      wr(3'd0, 8'h09);
      acc(16'h1234, 0, 1, 0, 2'd1, 16'h0);
      acc(16'h1234, 1, 1, 1, 2'd1, 16'h0);
      rd(3'd1, 8'h3F, "R4 read mode ignores write and fetch");
      acc(16'h1234, 1, 1, 0, 2'd1, 16'h0);
      rd(3'd1, 8'hBF, "R4 read mode hit"); wr(3'd1, 8'h00);
      // R4 write mode
      wr(3'd0, 8'h0A);
      acc(16'h1234, 1, 1, 0, 2'd1, 16'h0);
      rd(3'd1, 8'h3F, "R4 write mode ignores read");
      acc(16'h1234, 0, 1, 0, 2'd1, 16'h0);
      rd(3'd1, 8'hBF, "R4 write mode hit"); wr(3'd1, 8'h00);
      // R4 any mode
      wr(3'd0, 8'h0B);
      acc(16'h1234, 1, 1, 1, 2'd1, 16'h0);
      rd(3'd1, 8'h3F, "R4 any mode ignores fetch");
      acc(16'h1234, 0, 0, 0, 2'd1, 16'h0);
      rd(3'd1, 8'hBF, "R4 any mode write hit"); wr(3'd1, 8'h00);
      acc(16'h1234, 1, 0, 0, 2'd1, 16'h0);
      rd(3'd1, 8'hBF, "R4 any mode read hit"); wr(3'd1, 8'h00);

      // R6 byte accesses use the upper lane
      wr(3'd0, 8'h0F); wr(3'd3, 8'h35);
      acc(16'h1235, 1, 0, 0, 2'd1, 16'h005A);
      rd(3'd1, 8'h3F, "R6 byte odd lower lane ignored");
      acc(16'h1235, 1, 0, 0, 2'd1, 16'hA500);
      rd(3'd1, 8'hBF, "R6 byte odd upper lane"); wr(3'd1, 8'h00);

      // R7 word lane selection
      acc(16'h1235, 1, 1, 0, 2'd1, 16'hA500);
      rd(3'd1, 8'h3F, "R7 word odd RAM ignores upper");
      acc(16'h1235, 1, 1, 0, 2'd1, 16'h005A);
      rd(3'd1, 8'hBF, "R7 word odd RAM lower lane"); wr(3'd1, 8'h00);
      acc(16'h1235, 1, 1, 0, 2'd3, 16'h005A);
      rd(3'd1, 8'hBF, "R7 word odd IO16 lower lane"); wr(3'd1, 8'h00);
      acc(16'h1235, 1, 1, 0, 2'd2, 16'h005A);
      rd(3'd1, 8'h3F, "R7 word odd IO8 ignores lower");
      acc(16'h1235, 1, 1, 0, 2'd2, 16'hA500);
      rd(3'd1, 8'hBF, "R7 word odd IO8 upper lane"); wr(3'd1, 8'h00);
      wr(3'd3, 8'h34);
      acc(16'h1234, 1, 1, 0, 2'd0, 16'h005A);
      rd(3'd1, 8'h3F, "R7 word even ignores lower");
      acc(16'h1234, 1, 1, 0, 2'd0, 16'hA5FF);
      rd(3'd1, 8'hBF, "R7 word even upper lane"); wr(3'd1, 8'h00);

      // R9 match wins over a same-cycle clear
      acc(16'h1234, 1, 1, 0, 2'd0, 16'hA500);
      rd(3'd1, 8'hBF, "R9 arm");
      bus_addr = 16'h1234; bus_rnw = 1; bus_word = 1; bus_fetch = 0;
      bus_region = 2'd0; bus_data = 16'hA500; bus_valid = 1;
      wr(3'd1, 8'h00);
      bus_valid = 0;
      rd(3'd1, 8'hBF, "R9 flag kept");
      wr(3'd1, 8'h00);
      rd(3'd1, 8'h3F, "R9 cleared after");

      // R10 registered interrupt level
      wr(3'd1, 8'h40);
      acc(16'h1234, 1, 1, 0, 2'd0, 16'hA500);
      chk({15'd0, irq_o}, 16'd0, "R10 irq lags flag");
      reg_sel = 3'd0; step();
      chk({15'd0, irq_o}, 16'd1, "R10 irq asserted");
      clear_flag(8'h40);
      chk({15'd0, irq_o}, 16'd1, "R10 irq lags clear");
      step();
      chk({15'd0, irq_o}, 16'd0, "R10 irq dropped");
      rd(3'd1, 8'h7F, "R10 enable kept");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule